// File: doc/BRIEF.md
# Asynchronous-Bus Register Bank with Clock-Domain Strobes

This block is a small memory-mapped register file placed between an external processor memory bus and peripheral logic that runs on its own clock. The bus has no clock. It presents active-low chip select, write and read strobes, an address and write data. It holds address and data steady for as long as a strobe is low. Each register is described by four parameters: its width, its offset from a common base address, its access type and its reset value. The register set is fixed at elaboration time.

The three bus strobes are brought into the internal clock domain through a two-flop synchronizer. A rising-edge detector follows it. A small controller then turns each bus access into one internal event. A write updates the addressed register and raises that register's write strobe for one internal clock cycle. A read captures the addressed value onto the bus read-data lines and raises that register's read strobe for one cycle. Peripheral logic can use the read strobe for clear-on-read or pop-on-read behaviour.

The controller has four states. IDLE waits for a rising edge on the synchronized write or read request. A write edge goes to WRITE, and a write takes priority if both edges arrive together. A read edge goes to READ. WRITE and READ each last exactly one cycle and always move on to HOLD. HOLD waits until both synchronized requests are inactive and then returns to IDLE. Because of HOLD, a bus strobe held low for a long time yields only one internal event.

Top module: `regbank_top`

## Requirements
- R1: On reset, and on any later reset, every stored register returns to its reset value masked to the register's width. The read-data lines go to zero and no strobe is high. With default parameters `reg_out` is then 0x0011_003C_0000_A5A5, where register 0 is the lowest 16 bits.
- R2: Setup rule: a bus strobe goes low before a rising clock edge. The internal strobe is then high exactly in the cycle that begins at the third rising edge after that. Stored values change at the fourth rising edge.
- R3: A write stores only the low bits up to the register's width. Bits above the width are stored and read back as zero. With defaults, writing 0xFFFF to the 5-bit register at 0x4C reads back 0x001F.
- R4: A write to a read-only register changes no output of `reg_out` and produces no write strobe.
- R5: A read of a write-only register returns zero and produces no read strobe. A write to it updates its `reg_out` field and pulses its write strobe.
- R6: A read of a read-only register returns the register's slice of `status_in`, masked to its width, as sampled during the internal read cycle. It pulses that register's read strobe.
- R7: A read of a read/write register returns its stored value and pulses its read strobe.
- R8: An access to an address that matches no register returns zero on a read, produces no strobe and changes no stored value. With defaults, registers sit at the base 0x40 plus offsets 0x0, 0x4, 0x8 and 0xC. They are read/write 16-bit, read-only 12-bit, write-only 8-bit and read/write 5-bit respectively.
- R9: Across all write and read strobes, at most one bit is high in any cycle. Each strobe lasts one cycle. Each bus access yields at most one strobe, however long the bus strobe stays low.
- R10: `reg_out` changes only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset, internal domain |
| bus_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_we_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_re_n | input | 1 | Bus read strobe, active low, asynchronous |
| bus_addr | input | AW | Bus address, held stable while a strobe is low |
| bus_wdata | input | DW | Bus write data, held stable while the write strobe is low |
| bus_rdata | output | DW | Read data captured by the most recent read access |
| status_in | input | NREG*DW | Status value per register, used by read-only registers |
| reg_out | output | NREG*DW | Stored value per register; zero for read-only registers |
| wr_strobe | output | NREG | One-cycle write strobe per register, internal clock |
| rd_strobe | output | NREG | One-cycle read strobe per register, internal clock |

## Verification
The bench uses the default parameters: four registers on a 16-bit bus at base 0x40, with widths of 16, 12, 8 and 5 bits. One register has each of the three access types, and a second read/write register has a narrow width. With this set, one run covers width masking below the bus width, all three access types side by side, and an address just past the last register that exercises the no-match path. Because the base is not zero, an address that ignores the base lands on no register. A bus strobe held for forty cycles, a reset in the middle of the run and a change of status between two reads cover the single-event rule, reset recovery and live sampling of status.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [1:0] {
        ACC_RO = 2'd0,
        ACC_WO = 2'd1,
        ACC_RW = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_READ  = 2'd2,
        S_HOLD  = 2'd3
    } bank_state_e;

endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rb_rise.sv
module rb_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/rb_decode.sv
module rb_decode #(
    parameter int                  NREG    = 4,
    parameter int                  AW      = 8,
    parameter logic [AW-1:0]       BASE    = '0,
    parameter logic [NREG*AW-1:0]  OFFSETS = '0
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_match
        localparam logic [AW-1:0] SLOT_ADDR = AW'(BASE + OFFSETS[i*AW +: AW]);
        assign hit[i] = (addr == SLOT_ADDR);
    end
endmodule

// File: rtl/rb_slot.sv
module rb_slot #(
    parameter int          DW    = 16,
    parameter int          WIDTH = 16,
    parameter logic [1:0]  ACC   = 2'd2,
    parameter logic [DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] q,
    output logic [DW-1:0] rd_val
);
    import rb_pkg::*;

    localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - WIDTH);
    localparam acc_e          KIND = acc_e'(ACC);

    logic unused_in;
    assign unused_in = ^{status, wdata, we, clk, rst_n};

    if (KIND == ACC_RO) begin : g_ro
        assign q      = '0;
        assign rd_val = status & MASK;
    end else begin : g_store
        logic [DW-1:0] store;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  store <= INIT & MASK;
            else if (we) store <= wdata & MASK;
        end

        assign q = store;
        if (KIND == ACC_WO) begin : g_wo
            assign rd_val = '0;
        end else begin : g_rw
            assign rd_val = store;
        end
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import rb_pkg::*;
#(
    parameter int                 NREG     = 4,
    parameter int                 DW       = 16,
    parameter int                 AW       = 8,
    parameter logic [AW-1:0]      BASE     = 8'h40,
    parameter logic [NREG*AW-1:0] OFFSETS  = {8'h0C, 8'h08, 8'h04, 8'h00},
    parameter logic [NREG*8-1:0]  WIDTHS   = {8'd5, 8'd8, 8'd12, 8'd16},
    parameter logic [NREG*2-1:0]  ACCESS   = {2'd2, 2'd1, 2'd0, 2'd2},
    parameter logic [NREG*DW-1:0] DEFAULTS = {16'h0011, 16'h003C, 16'h0000, 16'hA5A5}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cs_n,
    input  logic               bus_we_n,
    input  logic               bus_re_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NREG*DW-1:0] status_in,
    output logic [NREG*DW-1:0] reg_out,
    output logic [NREG-1:0]    wr_strobe,
    output logic [NREG-1:0]    rd_strobe
);
    // bus strobes, bit 2 = select, 1 = write, 0 = read (active high here)
    logic [2:0] bus_raw;
    logic [2:0] bus_sync;
    logic       wr_lvl, rd_lvl;
    logic [1:0] req_rise;

    assign bus_raw = {~bus_cs_n, ~bus_we_n, ~bus_re_n};

    rb_sync #(.N(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_sync)
    );

    assign wr_lvl = bus_sync[2] & bus_sync[1];
    assign rd_lvl = bus_sync[2] & bus_sync[0];

    rb_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({wr_lvl, rd_lvl}),
        .rise  (req_rise)
    );

    logic [NREG-1:0] hit;

    rb_decode #(.NREG(NREG), .AW(AW), .BASE(BASE), .OFFSETS(OFFSETS)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    // per-register permission and storage
    logic [NREG-1:0] wr_ok, rd_ok;
    logic [DW-1:0]   rd_val [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam acc_e KIND  = acc_e'(ACCESS[i*2 +: 2]);
        localparam int   WIDTH = int'(WIDTHS[i*8 +: 8]);

        assign wr_ok[i] = hit[i] && (KIND != ACC_RO);
        assign rd_ok[i] = hit[i] && (KIND != ACC_WO);

        rb_slot #(
            .DW    (DW),
            .WIDTH (WIDTH),
            .ACC   (ACCESS[i*2 +: 2]),
            .INIT  (DEFAULTS[i*DW +: DW])
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_strobe[i]),
            .wdata  (bus_wdata),
            .status (status_in[i*DW +: DW]),
            .q      (reg_out[i*DW +: DW]),
            .rd_val (rd_val[i])
        );
    end

    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rd_mux = rd_mux | rd_val[i];
    end

    // controller
    bank_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_rise[1])      state_nx = S_WRITE;
                else if (req_rise[0]) state_nx = S_READ;
            end
            S_WRITE: state_nx = S_HOLD;
            S_READ:  state_nx = S_HOLD;
            S_HOLD: begin
                if (!wr_lvl && !rd_lvl) state_nx = S_IDLE;
            end
        endcase
    end

    always_comb begin
        wr_strobe = '0;
        rd_strobe = '0;
        unique case (state)
            S_WRITE: wr_strobe = wr_ok;
            S_READ:  rd_strobe = rd_ok;
            S_IDLE, S_HOLD: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (state == S_READ)  bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
    parameter int                NREG   = 4,
    parameter int                DW     = 16,
    parameter logic [NREG*2-1:0] ACCESS = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NREG-1:0]    wr_strobe,
    input logic [NREG-1:0]    rd_strobe,
    input logic [NREG*DW-1:0] reg_out
);
    p_onehot_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, rd_strobe}));

    p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe) |=> (wr_strobe == '0));

    p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_strobe) |=> (rd_strobe == '0));

    p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe == '0) |=> $stable(reg_out));

    for (genvar i = 0; i < NREG; i++) begin : g_acc
        if (ACCESS[i*2 +: 2] == 2'd0) begin : g_ro
            p_ro_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_strobe[i]);
        end else if (ACCESS[i*2 +: 2] == 2'd1) begin : g_wo
            p_wo_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_strobe[i]);
        end
    end
endmodule

bind regbank_top regbank_checker #(
    .NREG   (NREG),
    .DW     (DW),
    .ACCESS (ACCESS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .reg_out   (reg_out)
);

// File: tb/tb_regbank_top.sv
module tb_regbank_top;
    localparam int NREG = 4;
    localparam int DW   = 16;
    localparam int AW   = 8;
    localparam realtime CYC = 4ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_cs_n = 1'b1, bus_we_n = 1'b1, bus_re_n = 1'b1;
    logic [AW-1:0]      bus_addr = '0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic [NREG*DW-1:0] status_in;
    logic [NREG*DW-1:0] reg_out;
    logic [NREG-1:0]    wr_strobe, rd_strobe;

    always #(CYC/2) clk = ~clk;

    regbank_top dut (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_in(status_in), .reg_out(reg_out),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
    );

    // independent model of the default register set
    localparam logic [DW-1:0] MASK [NREG] = '{16'hFFFF, 16'h0FFF, 16'h00FF, 16'h001F};
    localparam bit            WRBL [NREG] = '{1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [NREG*DW-1:0] RESET_OUT = 64'h0011_003C_0000_A5A5;

    int errors = 0;
    int total  = 0;
    bit done   = 0;
    logic [NREG*DW-1:0] model_out;

    // strobe monitor
    int wr_cnt [NREG];
    int rd_cnt [NREG];
    int neg_idx, first_neg;

    always @(negedge clk) begin
        neg_idx = neg_idx + 1;
        for (int i = 0; i < NREG; i++) begin
            if (wr_strobe[i]) wr_cnt[i] = wr_cnt[i] + 1;
            if (rd_strobe[i]) rd_cnt[i] = rd_cnt[i] + 1;
        end
        if (((|wr_strobe) || (|rd_strobe)) && first_neg == 0) first_neg = neg_idx;
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic access(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int hold);
        @(posedge clk); #1;
        bus_addr  = a;
        bus_wdata = d;
        for (int i = 0; i < NREG; i++) begin wr_cnt[i] = 0; rd_cnt[i] = 0; end
        neg_idx   = 0;
        first_neg = 0;
        bus_cs_n  = 1'b0;
        if (rd) bus_re_n = 1'b0; else bus_we_n = 1'b0;
        repeat (hold) @(posedge clk);
        #1;
        bus_cs_n = 1'b1; bus_we_n = 1'b1; bus_re_n = 1'b1;
        repeat (6) @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [2:0]  idx;   // 4 = no strobe expected
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h40, 16'h1234, 16'h0000, 3'd0},  // R7 write RW
        '{1'b1, 8'h40, 16'h0000, 16'h1234, 3'd0},  // R7 read back
        '{1'b0, 8'h4C, 16'hFFFF, 16'h0000, 3'd3},  // R3 narrow write
        '{1'b1, 8'h4C, 16'h0000, 16'h001F, 3'd3},  // R3 masked read
        '{1'b0, 8'h44, 16'h7777, 16'h0000, 3'd4},  // R4 write to RO
        '{1'b1, 8'h44, 16'h0000, 16'h0BCD, 3'd1},  // R6 status read
        '{1'b0, 8'h48, 16'hABCD, 16'h0000, 3'd2},  // R5 write WO
        '{1'b1, 8'h48, 16'h0000, 16'h0000, 3'd4},  // R5 read WO
        '{1'b0, 8'h50, 16'h5555, 16'h0000, 3'd4},  // R8 unmapped write
        '{1'b1, 8'h50, 16'h0000, 16'h0000, 3'd4},  // R8 unmapped read
        '{1'b1, 8'h40, 16'h0000, 16'h1234, 3'd0}   // R8 no side effect
    };

    task automatic check_strobes(input string req, input bit rd, input int idx);
        for (int i = 0; i < NREG; i++) begin
            chk({req, " wr pulses"}, 64'(wr_cnt[i]), (!rd && i == idx) ? 64'd1 : 64'd0);
            chk({req, " rd pulses"}, 64'(rd_cnt[i]), ( rd && i == idx) ? 64'd1 : 64'd0);
        end
    endtask

    initial begin : watchdog
        #(CYC * 150000);
        if (!done) begin
            errors++;
            total++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin : main
        status_in = {16'h9999, 16'h9999, 16'hFBCD, 16'h9999};
        for (int i = 0; i < NREG; i++) begin wr_cnt[i] = 0; rd_cnt[i] = 0; end
        neg_idx = 0; first_neg = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset reg_out", 64'(reg_out), 64'(RESET_OUT));
        chk("R1 reset rdata", 64'(bus_rdata), 64'd0);
        chk("R1 reset strobes", 64'({wr_strobe, rd_strobe}), 64'd0);
        rst_n = 1'b1;
        model_out = RESET_OUT;

        // table walk
        for (int v = 0; v < NV; v++) begin
            access(VEC[v].rd, VEC[v].addr, VEC[v].wdata, 10);
            check_strobes($sformatf("R9 vec%0d", v), VEC[v].rd, int'(VEC[v].idx));
            if (VEC[v].idx != 3'd4)
                chk($sformatf("R2 vec%0d strobe timing", v), 64'(first_neg), 64'd4);
            if (VEC[v].rd) begin
                chk($sformatf("R6/R7/R5 vec%0d rdata", v), 64'(bus_rdata), 64'(VEC[v].exp));
            end else if (VEC[v].idx != 3'd4 && WRBL[VEC[v].idx]) begin
                model_out[VEC[v].idx*DW +: DW] = VEC[v].wdata & MASK[VEC[v].idx];
            end
            chk($sformatf("R4/R8 vec%0d reg_out", v), 64'(reg_out), 64'(model_out));
        end

        // R6: status is sampled at read time
        status_in[DW +: DW] = 16'h0456;
        access(1'b1, 8'h44, 16'h0, 10);
        chk("R6 new status", 64'(bus_rdata), 64'h0456);

        // R9: long bus strobe gives one event
        access(1'b0, 8'h4C, 16'h000A, 40);
        chk("R9 long hold single pulse", 64'(wr_cnt[3]), 64'd1);
        model_out[3*DW +: DW] = 16'h000A;
        chk("R10 reg_out after long write", 64'(reg_out), 64'(model_out));

        // R2: value not visible before the fourth edge
        @(posedge clk); #1;
        bus_addr = 8'h40; bus_wdata = 16'hBEEF;
        bus_cs_n = 1'b0; bus_we_n = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk("R2 value unchanged after 3 edges", 64'(reg_out[DW-1:0]), 64'h1234);
        @(posedge clk); #1;
        chk("R2 value updated at 4th edge", 64'(reg_out[DW-1:0]), 64'hBEEF);
        bus_cs_n = 1'b1; bus_we_n = 1'b1;
        repeat (6) @(posedge clk); #1;

        // R1: reset during operation restores defaults
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R1 mid-run reset reg_out", 64'(reg_out), 64'(RESET_OUT));
        chk("R1 mid-run reset rdata", 64'(bus_rdata), 64'd0);
        rst_n = 1'b1;
        access(1'b1, 8'h40, 16'h0, 10);
        chk("R1 R7 read default", 64'(bus_rdata), 64'hA5A5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule